// File: doc/BRIEF.md
# EDO DRAM Strobe Sequencer

This block sits between a simple host request port and a 72-bit-wide asynchronous EDO DRAM array of 8M words. The array has no clock, so the block turns every analog timing limit of the DRAM into a clock-cycle count given as a module parameter. Each strobe phase waits on one down-counter that is loaded from the count for the next phase. After reset the block waits out the power-up pause. It then runs a fixed number of /RAS-only refresh cycles to initialize the array. Only after that does it accept host requests.

A host request is a read or a write. A write takes one of three orderings. In an early write, /WE falls before /CAS and the DRAM output stays off. In a delayed write, /CAS falls first and /WE falls later. A read-modify-write reads the word with /OE low, turns the DRAM output off, and then writes. The block drives the multiplexed row and column address, the four active-low strobes and an enable for its own data-bus drivers. Each access ends with a one-cycle acknowledge and a /RAS precharge.

States: S_PAUSE, S_INIT_PRE, S_INIT_RAS, S_PRE, S_IDLE, S_RSET, S_RCD, S_CSET, S_CAS_W, S_CAS_RD, S_OE_OFF, S_DSET, S_WE_LOW. The transitions are:

- Initialization: S_PAUSE→S_INIT_PRE→S_INIT_RAS. S_INIT_RAS goes back to S_INIT_PRE until the last refresh, and then to S_PRE. S_PRE→S_IDLE.
- Access set-up: S_IDLE→S_RSET on an accepted request, then S_RSET→S_RCD→S_CSET.
- Early write: S_CSET→S_CAS_W→S_PRE.
- Other requests: S_CSET→S_CAS_RD. A read then goes S_CAS_RD→S_PRE. A delayed write or read-modify-write goes S_CAS_RD→S_OE_OFF→S_DSET→S_WE_LOW→S_PRE.

Top module: `edo_dram_seq`

## Requirements
- R1: After reset is released, all four strobes stay high (inactive) for at least PAUSE_US×CLK_MHZ cycles before the first /RAS fall.
- R2: After the pause, INIT_CYCLES (default 8) /RAS-only refresh cycles run. During these, /CAS stays high, each /RAS low lasts at least T_RAS cycles and each precharge at least T_RP cycles. init_done rises after the last one.
- R3: While init_done is low, a host request gets no ack and causes no strobe activity.
- R4: Early write (host_wr=1, host_mode=2'b00): /WE is low and write data is driven at least max(T_WCS,T_DS) cycles before /CAS falls. /OE stays high for the whole cycle.
- R5: Delayed write (host_wr=1, host_mode=2'b01, and the unused code 2'b11): /CAS falls with /WE high and /OE stays high. /WE falls at least T_CWD cycles after /CAS falls. Data is driven at least T_DS cycles before /WE falls and held at least T_DH cycles from it.
- R6: Read-modify-write (host_wr=1, host_mode=2'b10): the old word is read with /OE low and returned on host_rdata. /OE is then high for at least T_OEZ cycles before data drive starts. /WE falls at least max(T_AA,T_CAC,T_ACP,T_CWD) cycles after /CAS falls, and the new word is written.
- R7: Read (host_wr=0, host_mode ignored): the data bus is captured no earlier than the end of cycle max(T_AA,T_CAC,T_ACP) counted from the /CAS fall. host_rdata holds the word read.
- R8: dram_addr carries the row host_addr[22:11] when /RAS falls, and the column {1'b0, host_addr[10:0]} when /CAS falls.
- R9: Each access ends with host_ack high for exactly one cycle, followed by a /RAS precharge of at least T_RP cycles.
- R10: dram_dq_oe is high only in the write-data phases, and never while /OE is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Request; hold until host_ack |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_mode | input | 2 | Write ordering: 00 early, 01 delayed, 10 read-modify-write, 11 delayed |
| host_addr | input | 23 | Word address, row in the upper 12 bits |
| host_wdata | input | 72 | Write word |
| host_rdata | output | 72 | Word read (read and read-modify-write) |
| host_ack | output | 1 | One-cycle completion pulse |
| init_done | output | 1 | High once initialization is finished |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_dq_out | output | 72 | Data toward the DRAM |
| dram_dq_oe | output | 1 | Enable for the block's own data drivers |
| dram_dq_in | input | 72 | Data from the DRAM |

## Verification
The bench's DRAM model returns a poison word until /CAS has been low for the full access count. A sequencer that sampled one cycle early would therefore hand back the wrong word instead of a stale but plausible one. Each write ordering is checked for its own reference edge. An early write whose /WE came late would be taken by the model as a delayed write, and a delayed write that drove data while /OE was low would show up as bus contention. Read-modify-write is checked for returning the old word and then storing the new one. A design that skipped the /OE-off gap, or let /WE fall too soon after /CAS, would fail the gap and delay measurements. Requests raised during the pause, and the absence of /CAS during the initialization refreshes, are watched at the strobe pins.

// File: rtl/edo_pkg.sv
package edo_pkg;

    typedef enum logic [1:0] {
        WM_EARLY   = 2'b00,
        WM_DELAYED = 2'b01,
        WM_RMW     = 2'b10,
        WM_SPARE   = 2'b11
    } wmode_e;

    typedef enum logic [3:0] {
        S_PAUSE,
        S_INIT_PRE,
        S_INIT_RAS,
        S_PRE,
        S_IDLE,
        S_RSET,
        S_RCD,
        S_CSET,
        S_CAS_W,
        S_CAS_RD,
        S_OE_OFF,
        S_DSET,
        S_WE_LOW
    } seq_state_e;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/edo_phase_timer.sv
module edo_phase_timer #(
    parameter int unsigned CW      = 16,
    parameter logic [CW-1:0] RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= RST_VAL;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // R1: the counter moves down by one per cycle unless it is reloaded
    AST_TIMER_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R1
endmodule

// File: rtl/edo_addr_mux.sv
module edo_addr_mux #(
    parameter int unsigned ROW_W = 12,
    parameter int unsigned COL_W = 11
) (
    input  logic [ROW_W+COL_W-1:0] word_addr,
    input  logic [ROW_W-1:0]       refresh_row,
    input  logic                   sel_col,
    input  logic                   sel_ref,
    output logic [ROW_W-1:0]       pin_addr
);
    localparam int unsigned PAD = ROW_W - COL_W;

    always_comb begin
        if (sel_ref)
            pin_addr = refresh_row;
        else if (sel_col)
            pin_addr = {{PAD{1'b0}}, word_addr[COL_W-1:0]};
        else
            pin_addr = word_addr[ROW_W+COL_W-1:COL_W];
    end
endmodule

// File: rtl/edo_dram_seq.sv
module edo_dram_seq
    import edo_pkg::*;
#(
    parameter int unsigned CLK_MHZ     = 50,
    parameter int unsigned PAUSE_US    = 200,
    parameter int unsigned INIT_CYCLES = 8,
    parameter int unsigned ROW_W       = 12,
    parameter int unsigned COL_W       = 11,
    parameter int unsigned DW          = 72,
    parameter int unsigned T_RP        = 3,
    parameter int unsigned T_RAS       = 4,
    parameter int unsigned T_ASR       = 1,
    parameter int unsigned T_RCD       = 2,
    parameter int unsigned T_ASC       = 1,
    parameter int unsigned T_CAS       = 2,
    parameter int unsigned T_WCS       = 2,
    parameter int unsigned T_DS        = 1,
    parameter int unsigned T_DH        = 2,
    parameter int unsigned T_WP        = 2,
    parameter int unsigned T_AA        = 3,
    parameter int unsigned T_CAC       = 2,
    parameter int unsigned T_ACP       = 4,
    parameter int unsigned T_CWD       = 3,
    parameter int unsigned T_OEZ       = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_req,
    input  logic                   host_wr,
    input  logic [1:0]             host_mode,
    input  logic [ROW_W+COL_W-1:0] host_addr,
    input  logic [DW-1:0]          host_wdata,
    output logic [DW-1:0]          host_rdata,
    output logic                   host_ack,
    output logic                   init_done,
    output logic                   dram_ras_n,
    output logic                   dram_cas_n,
    output logic                   dram_we_n,
    output logic                   dram_oe_n,
    output logic [ROW_W-1:0]       dram_addr,
    output logic [DW-1:0]          dram_dq_out,
    output logic                   dram_dq_oe,
    input  logic [DW-1:0]          dram_dq_in
);
    localparam int unsigned AW        = ROW_W + COL_W;
    localparam int unsigned PAUSE_CYC = CLK_MHZ * PAUSE_US;
    localparam int unsigned CW        = $clog2(PAUSE_CYC + 256);
    localparam int unsigned ICW       = $clog2(INIT_CYCLES + 1);
    localparam int unsigned T_ACC     = umax(umax(T_AA, T_CAC), T_ACP);
    localparam int unsigned T_EWSU    = umax(T_WCS, T_DS);
    localparam int unsigned T_EWHD    = umax(T_CAS, T_DH);
    localparam int unsigned T_RMWRD   = umax(T_ACC, T_CWD);
    localparam int unsigned T_WLOW    = umax(T_WP, T_DH);

    seq_state_e    state, state_nx;
    logic          tdone;
    logic [CW-1:0] tload_val;
    logic [ICW-1:0] init_cnt;
    logic [AW-1:0] op_addr;
    logic          op_wr;
    wmode_e        op_mode;
    logic [DW-1:0] op_wdata;
    logic          op_early, op_rmw, last_init;
    logic          sel_col, sel_ref;

    assign op_early  = op_wr && (op_mode == WM_EARLY);
    assign op_rmw    = op_wr && (op_mode == WM_RMW);
    assign last_init = (init_cnt == ICW'(INIT_CYCLES - 1));

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_PAUSE:    if (tdone) state_nx = S_INIT_PRE;
            S_INIT_PRE: if (tdone) state_nx = S_INIT_RAS;
            S_INIT_RAS: if (tdone) state_nx = last_init ? S_PRE : S_INIT_PRE;
            S_PRE:      if (tdone) state_nx = S_IDLE;
            S_IDLE:     if (host_req && init_done) state_nx = S_RSET;
            S_RSET:     if (tdone) state_nx = S_RCD;
            S_RCD:      if (tdone) state_nx = S_CSET;
            S_CSET:     if (tdone) state_nx = op_early ? S_CAS_W : S_CAS_RD;
            S_CAS_W:    if (tdone) state_nx = S_PRE;
            S_CAS_RD:   if (tdone) state_nx = op_wr ? S_OE_OFF : S_PRE;
            S_OE_OFF:   if (tdone) state_nx = S_DSET;
            S_DSET:     if (tdone) state_nx = S_WE_LOW;
            S_WE_LOW:   if (tdone) state_nx = S_PRE;
            default:    state_nx = S_PAUSE;
        endcase
    end

    // phase length of the state being entered, minus one
    always_comb begin
        unique case (state_nx)
            S_INIT_PRE, S_PRE: tload_val = CW'(T_RP - 1);
            S_INIT_RAS:        tload_val = CW'(T_RAS - 1);
            S_RSET:            tload_val = CW'(T_ASR - 1);
            S_RCD:             tload_val = CW'(T_RCD - 1);
            S_CSET:            tload_val = op_early ? CW'(T_EWSU - 1) : CW'(T_ASC - 1);
            S_CAS_W:           tload_val = CW'(T_EWHD - 1);
            S_CAS_RD:          tload_val = !op_wr ? CW'(T_ACC - 1)
                                         : (op_rmw ? CW'(T_RMWRD - 1) : CW'(T_CWD - 1));
            S_OE_OFF:          tload_val = CW'(T_OEZ - 1);
            S_DSET:            tload_val = CW'(T_DS - 1);
            S_WE_LOW:          tload_val = CW'(T_WLOW - 1);
            default:           tload_val = '0;
        endcase
    end

    edo_phase_timer #(.CW(CW), .RST_VAL(CW'(PAUSE_CYC - 1))) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_nx != state),
        .load_val (tload_val),
        .done     (tdone)
    );

    // state register and per-access latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_PAUSE;
            init_cnt   <= '0;
            init_done  <= 1'b0;
            host_ack   <= 1'b0;
            host_rdata <= '0;
            op_addr    <= '0;
            op_wr      <= 1'b0;
            op_mode    <= WM_EARLY;
            op_wdata   <= '0;
        end else begin
            state    <= state_nx;
            host_ack <= (state_nx == S_PRE) && (state != S_PRE) && (state != S_INIT_RAS);
            if (state == S_INIT_RAS && tdone) begin
                init_cnt <= init_cnt + 1'b1;
                if (last_init) init_done <= 1'b1;
            end
            if (state == S_IDLE && state_nx == S_RSET) begin
                op_addr  <= host_addr;
                op_wr    <= host_wr;
                op_mode  <= wmode_e'(host_mode);
                op_wdata <= host_wdata;
            end
            if (state == S_CAS_RD && tdone && (!op_wr || op_rmw))
                host_rdata <= dram_dq_in;
        end
    end

    // strobe and bus outputs
    always_comb begin
        dram_ras_n = 1'b1;
        dram_cas_n = 1'b1;
        dram_we_n  = 1'b1;
        dram_oe_n  = 1'b1;
        dram_dq_oe = 1'b0;
        sel_col    = 1'b0;
        sel_ref    = 1'b0;
        unique case (state)
            S_PAUSE, S_PRE, S_IDLE, S_RSET: ;
            S_INIT_PRE: sel_ref = 1'b1;
            S_INIT_RAS: begin sel_ref = 1'b1; dram_ras_n = 1'b0; end
            S_RCD:      dram_ras_n = 1'b0;
            S_CSET: begin
                dram_ras_n = 1'b0; sel_col = 1'b1;
                dram_we_n  = !op_early;
                dram_dq_oe = op_early;
            end
            S_CAS_W: begin
                dram_ras_n = 1'b0; dram_cas_n = 1'b0; sel_col = 1'b1;
                dram_we_n  = 1'b0; dram_dq_oe = 1'b1;
            end
            S_CAS_RD: begin
                dram_ras_n = 1'b0; dram_cas_n = 1'b0; sel_col = 1'b1;
                dram_oe_n  = op_wr && !op_rmw;
            end
            S_OE_OFF: begin
                dram_ras_n = 1'b0; dram_cas_n = 1'b0; sel_col = 1'b1;
            end
            S_DSET: begin
                dram_ras_n = 1'b0; dram_cas_n = 1'b0; sel_col = 1'b1;
                dram_dq_oe = 1'b1;
            end
            S_WE_LOW: begin
                dram_ras_n = 1'b0; dram_cas_n = 1'b0; sel_col = 1'b1;
                dram_we_n  = 1'b0; dram_dq_oe = 1'b1;
            end
            default: ;
        endcase
    end

    assign dram_dq_out = op_wdata;

    edo_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W)) u_amux (
        .word_addr   (op_addr),
        .refresh_row (ROW_W'(init_cnt)),
        .sel_col     (sel_col),
        .sel_ref     (sel_ref),
        .pin_addr    (dram_addr)
    );

    AST_NO_ACK_BEFORE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> (!host_ack && dram_cas_n)); // R3
    AST_REFRESH_NO_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_INIT_RAS) |-> (dram_cas_n && !dram_ras_n)); // R2
    AST_EARLY_DATA_AT_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_we_n) |-> (dram_dq_oe && $past(!dram_we_n))); // R4
    AST_DELAYED_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cas_n && op_wr && !op_rmw) |-> dram_oe_n); // R5
    AST_RMW_OE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_dq_oe) && !dram_cas_n |-> $past(dram_oe_n)); // R6
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack); // R9
    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> (dram_oe_n && !dram_ras_n)); // R10
endmodule

// File: tb/edo_dram_seq_bench.sv
module edo_dram_seq_bench;
    localparam int unsigned MHZ = 50, PUS = 200, NINIT = 8;
    localparam int unsigned PAUSE = MHZ * PUS;
    localparam int unsigned RP = 3, RAS = 4, RCD = 2, CAS = 2, WCS = 2, DS = 1, DH = 2;
    localparam int unsigned WP = 2, AA = 3, CAC = 2, ACP = 4, CWD = 3, OEZ = 2;
    localparam int unsigned ACC = 4;   // largest of AA, CAC, ACP
    localparam int unsigned EWSU = 2;  // larger of WCS, DS
    localparam int unsigned RMWD = 4;  // larger of ACC, CWD
    localparam logic [71:0] POISON = {9{8'hA5}};

    logic clk = 0, rst_n = 0;
    logic host_req = 0, host_wr = 0;
    logic [1:0] host_mode = 0;
    logic [22:0] host_addr = 0;
    logic [71:0] host_wdata = 0, host_rdata;
    logic host_ack, init_done;
    logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [11:0] dram_addr;
    logic [71:0] dram_dq_out, dram_dq_in;

    always #10 clk = ~clk;

    edo_dram_seq #(.CLK_MHZ(MHZ), .PAUSE_US(PUS), .INIT_CYCLES(NINIT), .T_RP(RP), .T_RAS(RAS),
        .T_RCD(RCD), .T_CAS(CAS), .T_WCS(WCS), .T_DS(DS), .T_DH(DH), .T_WP(WP), .T_AA(AA),
        .T_CAC(CAC), .T_ACP(ACP), .T_CWD(CWD), .T_OEZ(OEZ)) u_edo_dram_seq (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr), .host_mode(host_mode),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ack(host_ack), .init_done(init_done), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_addr(dram_addr), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
        .dram_dq_in(dram_dq_in));

    // ---------------- DRAM model and pin monitor ----------------
    logic [71:0] mem [logic [22:0]];
    int cyc, ras_falls, cas_falls, ras_fall_cyc, cas_fall_cyc, we_fall_cyc, first_ras_cyc;
    int cas_low_cnt, last_oe_low_cyc, dq_rise_cyc, dq_last_cyc, contention, bad_drive;
    int wr_caps, ack_run, max_ack_run, ras_low_run, ras_high_run, min_ras_low, min_ras_high;
    bit oe_low_seen, dq_seen;
    logic [11:0] cur_row;
    logic [10:0] cur_col;
    logic [71:0] rd_word;
    logic prv_ras, prv_cas, prv_we, prv_dq, prv_ack;

    assign dram_dq_in = (!dram_oe_n && cas_low_cnt >= int'(ACC)) ? rd_word : POISON;

    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0; ras_falls = 0; cas_falls = 0; first_ras_cyc = -1; cas_low_cnt = 0;
            prv_ras = 1; prv_cas = 1; prv_we = 1; prv_dq = 0; prv_ack = 0;
            ras_low_run = 0; ras_high_run = 0; min_ras_low = 1 << 20; min_ras_high = 1 << 20;
            contention = 0; bad_drive = 0; wr_caps = 0; max_ack_run = 0; ack_run = 0;
            oe_low_seen = 0; dq_seen = 0; rd_word = '0; cur_row = '0; cur_col = '0;
        end else begin
            cyc++;
            if (prv_ras && !dram_ras_n) begin
                ras_falls++; ras_fall_cyc = cyc; cur_row = dram_addr;
                if (first_ras_cyc < 0) first_ras_cyc = cyc;
                if (first_ras_cyc != cyc && ras_high_run < min_ras_high) min_ras_high = ras_high_run;
            end
            if (!dram_ras_n) begin ras_low_run++; ras_high_run = 0; end
            else begin
                if (!prv_ras && ras_low_run < min_ras_low) min_ras_low = ras_low_run;
                ras_low_run = 0; ras_high_run++;
            end
            if (prv_cas && !dram_cas_n) begin
                cas_falls++; cas_fall_cyc = cyc; cur_col = dram_addr[10:0];
                rd_word = mem.exists({cur_row, cur_col}) ? mem[{cur_row, cur_col}] : '0;
                if (!dram_we_n) begin
                    mem[{cur_row, cur_col}] = dram_dq_out; wr_caps++;
                    if (!dram_dq_oe) bad_drive++;
                end
            end else if (prv_we && !dram_we_n && !dram_cas_n) begin
                mem[{cur_row, cur_col}] = dram_dq_out; wr_caps++;
                if (!dram_dq_oe) bad_drive++;
            end
            if (prv_we && !dram_we_n) we_fall_cyc = cyc;
            cas_low_cnt = dram_cas_n ? 0 : cas_low_cnt + 1;
            if (!dram_oe_n) begin oe_low_seen = 1; last_oe_low_cyc = cyc; end
            if (dram_dq_oe && !dram_oe_n) contention++;
            if (dram_dq_oe && !prv_dq) dq_rise_cyc = cyc;
            if (dram_dq_oe) begin dq_last_cyc = cyc; dq_seen = 1; end
            if (host_ack) begin
                ack_run = prv_ack ? ack_run + 1 : 1;
                if (ack_run > max_ack_run) max_ack_run = ack_run;
            end
            prv_ras = dram_ras_n; prv_cas = dram_cas_n; prv_we = dram_we_n;
            prv_dq = dram_dq_oe; prv_ack = host_ack;
        end
    end

    // ---------------- check bookkeeping ----------------
    int n_chk = 0, n_bad = 0;
    bit done_flag = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_w(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    task automatic clear_flags();
        oe_low_seen = 0; dq_seen = 0; contention = 0; bad_drive = 0;
        wr_caps = 0; max_ack_run = 0;
    endtask

    task automatic access(input logic wr, input logic [1:0] md, input logic [22:0] a,
                          input logic [71:0] d, output logic [71:0] rd, output bit ok);
        clear_flags();
        @(negedge clk);
        host_req = 1; host_wr = wr; host_mode = md; host_addr = a; host_wdata = d;
        ok = 0; rd = '0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (host_ack) begin ok = 1; rd = host_rdata; break; end
        end
        host_req = 0; host_wdata = '0;
        repeat (RP + 3) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_and_pause();
        rst_n = 0;
        repeat (3) @(negedge clk);
        check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n && !dram_dq_oe && !init_done && !host_ack,
              "R1 reset state", {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe}, 5'b11110);
        rst_n = 1;
        host_req = 1; host_wr = 1; host_mode = 2'b00; host_addr = 23'h1; host_wdata = 72'h5;
        begin
            int acks = 0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (host_ack) acks++;
            end
            check(acks == 0 && ras_falls == 0 && cas_falls == 0, "R3 request during pause",
                  acks + ras_falls + cas_falls, 0);
        end
        host_req = 0;
    endtask

    task automatic t_init();
        int guard = 0;
        while (!init_done && guard < PAUSE + 1000) begin @(negedge clk); guard++; end
        check(init_done, "R2 init_done rises", init_done, 1);
        check(first_ras_cyc >= int'(PAUSE), "R1 pause length", first_ras_cyc, PAUSE);
        check(ras_falls == int'(NINIT), "R2 refresh count", ras_falls, NINIT);
        check(cas_falls == 0, "R2 RAS-only refresh keeps CAS high", cas_falls, 0);
        repeat (RP + 2) @(negedge clk);
        check(min_ras_low >= int'(RAS), "R2 refresh RAS low width", min_ras_low, RAS);
        check(min_ras_high >= int'(RP), "R2 refresh precharge", min_ras_high, RP);
    endtask

    task automatic t_early(input logic [22:0] a, input logic [71:0] d);
        logic [71:0] rd; bit ok;
        access(1'b1, 2'b00, a, d, rd, ok);
        check(ok, "R9 early write ack", ok, 1);
        check(cas_fall_cyc - we_fall_cyc >= int'(EWSU), "R4 WE before CAS",
              cas_fall_cyc - we_fall_cyc, EWSU);
        check(!oe_low_seen && bad_drive == 0 && wr_caps == 1, "R4 OE high, data at CAS",
              {oe_low_seen, 8'(bad_drive), 8'(wr_caps)}, 1);
        check(cur_row == a[22:11] && cur_col == a[10:0], "R8 row/col split",
              {cur_row, cur_col}, a);
        check(max_ack_run == 1, "R9 ack one cycle", max_ack_run, 1);
    endtask

    task automatic t_read(input logic [22:0] a, input logic [1:0] md, input logic [71:0] exp);
        logic [71:0] rd; bit ok;
        access(1'b0, md, a, 72'hFFFF, rd, ok);
        check(ok, "R9 read ack", ok, 1);
        check_w(rd == exp, "R7 read data after full access time", rd, exp);
        check(!dq_seen && contention == 0 && wr_caps == 0, "R10 no drive during read",
              dq_seen, 0);
        check(cur_row == a[22:11] && cur_col == a[10:0], "R8 read address", {cur_row, cur_col}, a);
    endtask

    task automatic t_delayed(input logic [22:0] a, input logic [1:0] md, input logic [71:0] d);
        logic [71:0] rd; bit ok;
        access(1'b1, md, a, d, rd, ok);
        check(ok, "R5 delayed write ack", ok, 1);
        check(we_fall_cyc - cas_fall_cyc >= int'(CWD), "R5 CAS to WE delay",
              we_fall_cyc - cas_fall_cyc, CWD);
        check(!oe_low_seen && contention == 0, "R5 OE stays high", oe_low_seen, 0);
        check(we_fall_cyc - dq_rise_cyc >= int'(DS), "R5 data setup to WE",
              we_fall_cyc - dq_rise_cyc, DS);
        check(dq_last_cyc - we_fall_cyc + 1 >= int'(DH), "R5 data hold from WE",
              dq_last_cyc - we_fall_cyc + 1, DH);
        check(wr_caps == 1 && bad_drive == 0, "R5 one write on WE edge", wr_caps, 1);
    endtask

    task automatic t_rmw(input logic [22:0] a, input logic [71:0] d, input logic [71:0] old);
        logic [71:0] rd; bit ok;
        access(1'b1, 2'b10, a, d, rd, ok);
        check(ok, "R6 rmw ack", ok, 1);
        check_w(rd == old, "R6 rmw returns old word", rd, old);
        check(oe_low_seen && contention == 0, "R6 OE low for read part, no contention",
              contention, 0);
        check(dq_rise_cyc - last_oe_low_cyc - 1 >= int'(OEZ), "R6 OE off before drive",
              dq_rise_cyc - last_oe_low_cyc - 1, OEZ);
        check(we_fall_cyc - cas_fall_cyc >= int'(RMWD), "R6 WE delay from CAS",
              we_fall_cyc - cas_fall_cyc, RMWD);
        check(max_ack_run == 1, "R9 rmw ack one cycle", max_ack_run, 1);
    endtask

    initial begin
        t_reset_and_pause();
        t_init();
        t_early(23'h12_3456, 72'hAB_0123_4567_89AB_CDEF);
        t_read(23'h12_3456, 2'b00, 72'hAB_0123_4567_89AB_CDEF);
        t_early(23'h7F_FFFF, {72{1'b1}});
        t_read(23'h7F_FFFF, 2'b11, {72{1'b1}});      // R7 mode bits ignored on read
        t_read(23'h00_0000, 2'b01, 72'h0);            // R7 unwritten word
        t_delayed(23'h00_0000, 2'b01, 72'h55_AAAA_5555_AAAA_5555);
        t_read(23'h00_0000, 2'b10, 72'h55_AAAA_5555_AAAA_5555);
        t_delayed(23'h2A_AAAA, 2'b11, 72'h3C_0F0F_F0F0_1234_5678); // R5 spare code
        t_read(23'h2A_AAAA, 2'b00, 72'h3C_0F0F_F0F0_1234_5678);
        t_rmw(23'h12_3456, 72'h01_1111_2222_3333_4444, 72'hAB_0123_4567_89AB_CDEF);
        t_read(23'h12_3456, 2'b00, 72'h01_1111_2222_3333_4444);
        check(min_ras_high >= int'(RP), "R9 precharge after every access", min_ras_high, RP);
        check(contention == 0, "R10 no bus fight", contention, 0);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end
endmodule